// File: doc/BRIEF.md
# Cascadable Product-Term Sum Region

This block is one logic region of four macrocells that build sums of products over a shared input vector. Each macrocell holds five AND terms. A term can test any global input, and any line of a regional foldback bus, in true or complemented form. The terms that are not steered elsewhere are ORed into a local sum. That sum may also absorb the sum of the macrocell below it through a cascade link. The result then passes through an XOR stage, whose second operand is a constant 0, a constant 1, or one of the macrocell's own terms.

Each macrocell also drives one line of the foldback bus with the inverse of a chosen term. Any term in the region can pick up these four lines as literals, so one sum can reach nine terms without a cascade. Cascades run from macrocell 0 up to macrocell 3, and the top cascade output can feed the cascade input of another region. This lets chains of eight macrocells reach forty terms. All configuration arrives on static vectors, and the block is purely combinational.

Top module: `pt_sum_region`

## Requirements
- R1: Term k of macrocell m uses mask bits starting at bit (m*5+k)*20. Bits 0..15 of that slice refer to in_i[0..15], and bits 16..19 refer to fb_o[0..3]. A set bit in pos_mask_i requires its literal to be 1, and a set bit in neg_mask_i requires it to be 0. An enabled term with no bits set is 1. A term whose term_en_i bit (index m*5+k) is 0 is 0.
- R2: The sum of macrocell m is the OR of its terms that are not steered to the XOR stage, plus the admitted cascade. With all its terms disabled and no cascade admitted, the sum is 0.
- R3: casc_o[m] equals the sum of macrocell m. When casc_en_i[m] is 1, that sum also ORs in casc_o[m-1], or casc_i when m is 0. When casc_en_i[m] is 0, the cascade is ignored.
- R4: xor_o[m] is the sum of macrocell m XOR an operand chosen by xor_mode_i[2m+1:2m]. Code 0 gives 0, code 1 gives 1, code 2 gives the term indexed by xor_pt_i[3m+2:3m], and code 3 gives 0.
- R5: A term that mode 2 selects for the XOR operand is removed from that macrocell's OR sum.
- R6: fb_o[m] is the inverse of the term of macrocell m that fb_pt_i[3m+2:3m] indexes. Every term in the region can use it as a literal.
- R7: The term that feeds a macrocell's foldback line ignores its own foldback literals (mask bits 16..19), both for the bus and for the sum.
- R8: An index of 5 or more selects no term. On fb_pt_i this drives the foldback line to 1. On xor_pt_i in mode 2 it gives an operand of 0, and no term is removed from the sum.
- R9: For any configuration and input vector, all outputs match a sum-of-products model built from R1 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_i | input | 16 | Global input literals |
| casc_i | input | 1 | Cascade into macrocell 0 (tie to 0 on the first region) |
| pos_mask_i | input | 400 | True-literal masks, 20 bits per term |
| neg_mask_i | input | 400 | Complement-literal masks, 20 bits per term |
| term_en_i | input | 20 | Per-term enable |
| casc_en_i | input | 4 | Per-macrocell cascade admit |
| xor_mode_i | input | 8 | XOR operand code, 2 bits per macrocell |
| xor_pt_i | input | 12 | XOR operand term index, 3 bits per macrocell |
| fb_pt_i | input | 12 | Foldback source term index, 3 bits per macrocell |
| xor_o | output | 4 | XOR stage results |
| casc_o | output | 4 | Local sums including cascade |
| fb_o | output | 4 | Regional foldback bus |

## Verification
Two things can happen in the same evaluation. A macrocell can admit a cascade that is 1 while one of its terms is steered to the XOR operand. The cascade has to reach casc_o even though that term leaves the sum, and the steered term must still invert xor_o. A directed case drives casc_i high with every cascade admitted and steers an always-true term in macrocell 1. The expected pattern shows casc_o all ones, xor_o with bit 1 cleared, and the steered term also visible on fb_o. Randomised configurations, which mix steering, cascades and foldback literals, are checked against an independent model.

// File: rtl/pt_sum_pkg.sv
package pt_sum_pkg;
  localparam int unsigned PT_NUM_IN = 16;
  localparam int unsigned PT_NUM_MC = 4;
  localparam int unsigned PT_NUM_PT = 5;
  localparam int unsigned PT_IDX_W  = 3;

  typedef enum logic [1:0] {
    XOP_ZERO = 2'd0,
    XOP_ONE  = 2'd1,
    XOP_TERM = 2'd2,
    XOP_RSVD = 2'd3
  } xop_e;
endpackage

// File: rtl/pt_term.sv
module pt_term #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] lit_i,
  input  logic [W-1:0] pos_i,
  input  logic [W-1:0] neg_i,
  input  logic         en_i,
  output logic         hit_o
);
  // a term fails if any selected literal has the wrong level
  assign hit_o = en_i & ~|((pos_i & ~lit_i) | (neg_i & lit_i));
endmodule

// File: rtl/pt_xor_stage.sv
module pt_xor_stage
  import pt_sum_pkg::*;
(
  input  logic       sum_i,
  input  logic [1:0] mode_i,
  input  logic       term_i,
  output logic       y_o
);
  logic op;

  always_comb begin
    case (mode_i)
      XOP_ONE:  op = 1'b1;
      XOP_TERM: op = term_i;
      default:  op = 1'b0;
    endcase
  end

  assign y_o = sum_i ^ op;
endmodule

// File: rtl/pt_macrocell.sv
module pt_macrocell
  import pt_sum_pkg::*;
#(
  parameter int unsigned NUM_IN = PT_NUM_IN,
  parameter int unsigned NUM_MC = PT_NUM_MC,
  parameter int unsigned NUM_PT = PT_NUM_PT,
  parameter int unsigned IDX_W  = PT_IDX_W
) (
  input  logic [NUM_IN-1:0]                 in_i,
  input  logic [NUM_MC-1:0]                 fb_i,
  input  logic [NUM_PT*(NUM_IN+NUM_MC)-1:0] pos_i,
  input  logic [NUM_PT*(NUM_IN+NUM_MC)-1:0] neg_i,
  input  logic [NUM_PT-1:0]                 en_i,
  input  logic [1:0]                        xor_mode_i,
  input  logic [IDX_W-1:0]                  xor_pt_i,
  input  logic [IDX_W-1:0]                  fb_pt_i,
  input  logic                              casc_en_i,
  input  logic                              casc_i,
  output logic                              fb_o,
  output logic                              casc_o,
  output logic                              xor_o
);
  localparam int unsigned LW = NUM_IN + NUM_MC;

  logic [NUM_PT-1:0] term_g;
  logic [NUM_PT-1:0] term_f;
  logic [NUM_PT-1:0] term;
  logic [NUM_PT-1:0] fb_src;
  logic [NUM_PT-1:0] to_xor;
  logic              steer;
  logic              xop_term;

  assign steer = (xor_mode_i == XOP_TERM);

  for (genvar k = 0; k < NUM_PT; k++) begin : g_pt
    localparam int unsigned B = k * LW;

    pt_term #(.W(NUM_IN)) u_glb (
      .lit_i (in_i),
      .pos_i (pos_i[B +: NUM_IN]),
      .neg_i (neg_i[B +: NUM_IN]),
      .en_i  (en_i[k]),
      .hit_o (term_g[k])
    );

    pt_term #(.W(NUM_MC)) u_fbk (
      .lit_i (fb_i),
      .pos_i (pos_i[B+NUM_IN +: NUM_MC]),
      .neg_i (neg_i[B+NUM_IN +: NUM_MC]),
      .en_i  (1'b1),
      .hit_o (term_f[k])
    );

    assign fb_src[k] = (fb_pt_i == IDX_W'(k));
    assign to_xor[k] = steer && (xor_pt_i == IDX_W'(k));
    // foldback source skips its foldback literals: no loop through the bus
    assign term[k]   = term_g[k] & (fb_src[k] | term_f[k]);
  end

  always_comb begin
    fb_o     = 1'b1;
    xop_term = 1'b0;
    for (int unsigned k = 0; k < NUM_PT; k++) begin
      if (fb_src[k]) fb_o = ~term_g[k];
      if (xor_pt_i == IDX_W'(k)) xop_term = term[k];
    end
  end

  assign casc_o = (casc_en_i & casc_i) | (|(term & ~to_xor));

  pt_xor_stage u_xor (
    .sum_i  (casc_o),
    .mode_i (xor_mode_i),
    .term_i (xop_term),
    .y_o    (xor_o)
  );
endmodule

// File: rtl/pt_sum_region.sv
module pt_sum_region
  import pt_sum_pkg::*;
#(
  parameter int unsigned NUM_IN = PT_NUM_IN,
  parameter int unsigned NUM_MC = PT_NUM_MC,
  parameter int unsigned NUM_PT = PT_NUM_PT,
  parameter int unsigned IDX_W  = PT_IDX_W
) (
  input  logic [NUM_IN-1:0]                        in_i,
  input  logic                                     casc_i,
  input  logic [NUM_MC*NUM_PT*(NUM_IN+NUM_MC)-1:0] pos_mask_i,
  input  logic [NUM_MC*NUM_PT*(NUM_IN+NUM_MC)-1:0] neg_mask_i,
  input  logic [NUM_MC*NUM_PT-1:0]                 term_en_i,
  input  logic [NUM_MC-1:0]                        casc_en_i,
  input  logic [2*NUM_MC-1:0]                      xor_mode_i,
  input  logic [IDX_W*NUM_MC-1:0]                  xor_pt_i,
  input  logic [IDX_W*NUM_MC-1:0]                  fb_pt_i,
  output logic [NUM_MC-1:0]                        xor_o,
  output logic [NUM_MC-1:0]                        casc_o,
  output logic [NUM_MC-1:0]                        fb_o
);
  localparam int unsigned LW    = NUM_IN + NUM_MC;
  localparam int unsigned SLICE = NUM_PT * LW;

  logic [NUM_MC:0] chain;

  assign chain[0] = casc_i;

  for (genvar i = 0; i < NUM_MC; i++) begin : g_mc
    pt_macrocell #(
      .NUM_IN (NUM_IN),
      .NUM_MC (NUM_MC),
      .NUM_PT (NUM_PT),
      .IDX_W  (IDX_W)
    ) u_mc (
      .in_i       (in_i),
      .fb_i       (fb_o),
      .pos_i      (pos_mask_i[i*SLICE +: SLICE]),
      .neg_i      (neg_mask_i[i*SLICE +: SLICE]),
      .en_i       (term_en_i[i*NUM_PT +: NUM_PT]),
      .xor_mode_i (xor_mode_i[2*i +: 2]),
      .xor_pt_i   (xor_pt_i[IDX_W*i +: IDX_W]),
      .fb_pt_i    (fb_pt_i[IDX_W*i +: IDX_W]),
      .casc_en_i  (casc_en_i[i]),
      .casc_i     (chain[i]),
      .fb_o       (fb_o[i]),
      .casc_o     (chain[i+1]),
      .xor_o      (xor_o[i])
    );
    assign casc_o[i] = chain[i+1];
  end
endmodule

// File: rtl/pt_sum_region_chk.sv
module pt_sum_region_chk
  import pt_sum_pkg::*;
#(
  parameter int unsigned NUM_MC = PT_NUM_MC,
  parameter int unsigned NUM_PT = PT_NUM_PT,
  parameter int unsigned IDX_W  = PT_IDX_W
) (
  input logic [NUM_MC*NUM_PT-1:0]  term_en_i,
  input logic                      casc_i,
  input logic [NUM_MC-1:0]         casc_en_i,
  input logic [2*NUM_MC-1:0]       xor_mode_i,
  input logic [IDX_W*NUM_MC-1:0]   fb_pt_i,
  input logic [NUM_MC-1:0]         xor_o,
  input logic [NUM_MC-1:0]         casc_o,
  input logic [NUM_MC-1:0]         fb_o
);
  for (genvar i = 0; i < NUM_MC; i++) begin : g_chk
    logic       cin;
    logic [1:0] md;

    if (i == 0) begin : g_head
      assign cin = casc_i;
    end else begin : g_link
      assign cin = casc_o[i-1];
    end

    assign md = xor_mode_i[2*i +: 2];

    always_comb begin
      if (casc_en_i[i] && cin) begin
        AST_CASC_PASS: assert (casc_o[i]) else $error("cascade lost"); // R3
      end
      if (md == XOP_ZERO || md == XOP_RSVD) begin
        AST_XOR_ZERO: assert (xor_o[i] == casc_o[i]) else $error("xor const0"); // R4
      end
      if (md == XOP_ONE) begin
        AST_XOR_ONE: assert (xor_o[i] != casc_o[i]) else $error("xor const1"); // R4
      end
      if (fb_pt_i[IDX_W*i +: IDX_W] >= IDX_W'(NUM_PT)) begin
        AST_FB_IDLE: assert (fb_o[i]) else $error("foldback idle"); // R8
      end
      if (term_en_i[i*NUM_PT +: NUM_PT] == '0 && !(casc_en_i[i] && cin)) begin
        AST_SUM_IDLE: assert (!casc_o[i]) else $error("sum not idle"); // R2
      end
    end
  end
endmodule

bind pt_sum_region pt_sum_region_chk #(
  .NUM_MC (NUM_MC),
  .NUM_PT (NUM_PT),
  .IDX_W  (IDX_W)
) u_chk (.*);

// File: tb/pt_sum_region_test.sv
module pt_sum_region_test;
  localparam int unsigned NUM_IN = 16;
  localparam int unsigned NUM_MC = 4;
  localparam int unsigned NUM_PT = 5;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned LW     = NUM_IN + NUM_MC;
  localparam int unsigned NT     = NUM_MC * NUM_PT;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NVEC   = 8;

  // row: seed, inputs, cascade in, cascade admits
  localparam logic [52:0] VEC [NVEC] = '{
    {32'h0000_1234, 16'h0000, 1'b0, 4'hF},
    {32'h0BAD_F00D, 16'hFFFF, 1'b0, 4'hF},
    {32'h1357_9BDF, 16'hA5A5, 1'b1, 4'hF},
    {32'h2468_ACE0, 16'h5A5A, 1'b1, 4'h0},
    {32'h7777_0001, 16'h00FF, 1'b0, 4'hA},
    {32'h0C0F_FEE0, 16'hFF00, 1'b1, 4'h5},
    {32'h1111_2222, 16'h8001, 1'b0, 4'hE},
    {32'h3141_5926, 16'h0F0F, 1'b1, 4'h7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   n_tests = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  logic [NUM_IN-1:0]     in_v;
  logic                  casc_in;
  logic [NT*LW-1:0]      pos;
  logic [NT*LW-1:0]      neg;
  logic [NT-1:0]         ten;
  logic [NUM_MC-1:0]     cen;
  logic [2*NUM_MC-1:0]   xmode;
  logic [IDX_W*NUM_MC-1:0] xpt;
  logic [IDX_W*NUM_MC-1:0] fbpt;
  logic [NUM_MC-1:0]     xo, co, fo;
  logic [NUM_MC-1:0]     exp_xor, exp_casc, exp_fb;
  logic [31:0]           rng;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_sum_region uut (
    .in_i       (in_v),
    .casc_i     (casc_in),
    .pos_mask_i (pos),
    .neg_mask_i (neg),
    .term_en_i  (ten),
    .casc_en_i  (cen),
    .xor_mode_i (xmode),
    .xor_pt_i   (xpt),
    .fb_pt_i    (fbpt),
    .xor_o      (xo),
    .casc_o     (co),
    .fb_o       (fo)
  );

  function automatic logic [31:0] nxt();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic clear_cfg();
    in_v = '0; casc_in = 1'b0; pos = '0; neg = '0; ten = '0;
    cen = '0; xmode = '0; xpt = '0; fbpt = '0;
  endtask

  task automatic set_term(int m, int k, logic en, logic [LW-1:0] p, logic [LW-1:0] n);
    int idx;
    idx = m * NUM_PT + k;
    ten[idx] = en;
    pos[idx*LW +: LW] = p;
    neg[idx*LW +: LW] = n;
  endtask

  task automatic set_mc(int m, logic [1:0] md, logic [IDX_W-1:0] xp, logic [IDX_W-1:0] fp);
    xmode[2*m +: 2] = md;
    xpt[IDX_W*m +: IDX_W] = xp;
    fbpt[IDX_W*m +: IDX_W] = fp;
  endtask

  task automatic rand_cfg();
    logic [31:0] r;
    for (int idx = 0; idx < NT; idx++) begin
      r = nxt();
      ten[idx] = (r[1:0] != 2'b00);
      pos[idx*LW +: LW] = LW'(nxt() & nxt() & nxt() & nxt());
      neg[idx*LW +: LW] = LW'(nxt() & nxt() & nxt() & nxt()) & ~pos[idx*LW +: LW];
    end
    for (int m = 0; m < NUM_MC; m++) begin
      r = nxt();
      set_mc(m, r[1:0], r[4:2], r[7:5]);
    end
  endtask

  // independent sum-of-products model
  task automatic run_model();
    logic [NT-1:0] tg, tf;
    logic chain, s, ok;
    int f, md, xp, b;
    for (int idx = 0; idx < NT; idx++) begin
      b = idx * LW;
      ok = ten[idx];
      for (int j = 0; j < NUM_IN; j++) begin
        if (pos[b+j] && !in_v[j]) ok = 1'b0;
        if (neg[b+j] && in_v[j]) ok = 1'b0;
      end
      tg[idx] = ok;
    end
    for (int m = 0; m < NUM_MC; m++) begin
      f = int'(fbpt[IDX_W*m +: IDX_W]);
      exp_fb[m] = (f < NUM_PT) ? !tg[m*NUM_PT+f] : 1'b1;
    end
    for (int m = 0; m < NUM_MC; m++) begin
      f = int'(fbpt[IDX_W*m +: IDX_W]);
      for (int k = 0; k < NUM_PT; k++) begin
        b = (m*NUM_PT+k) * LW;
        ok = tg[m*NUM_PT+k];
        if (k != f) begin
          for (int j = 0; j < NUM_MC; j++) begin
            if (pos[b+NUM_IN+j] && !exp_fb[j]) ok = 1'b0;
            if (neg[b+NUM_IN+j] && exp_fb[j]) ok = 1'b0;
          end
        end
        tf[m*NUM_PT+k] = ok;
      end
    end
    chain = casc_in;
    for (int m = 0; m < NUM_MC; m++) begin
      md = int'(xmode[2*m +: 2]);
      xp = int'(xpt[IDX_W*m +: IDX_W]);
      s = cen[m] & chain;
      for (int k = 0; k < NUM_PT; k++)
        if (!(md == 2 && xp == k)) s = s | tf[m*NUM_PT+k];
      exp_casc[m] = s;
      if (md == 1) exp_xor[m] = s ^ 1'b1;
      else if (md == 2 && xp < NUM_PT) exp_xor[m] = s ^ tf[m*NUM_PT+xp];
      else exp_xor[m] = s;
      chain = s;
    end
  endtask

  task automatic check(string req, string what,
                       logic [NUM_MC-1:0] ex, logic [NUM_MC-1:0] ec, logic [NUM_MC-1:0] ef);
    @(negedge clk);
    n_tests++;
    if ({xo, co, fo} !== {ex, ec, ef}) begin
      n_fail++;
      $display("FAIL %s %s: act xor=%b casc=%b fb=%b exp xor=%b casc=%b fb=%b",
               req, what, xo, co, fo, ex, ec, ef);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: act running exp finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    clear_cfg();
    repeat (2) @(posedge clk);
    check("R2", "reset state", 4'b0000, 4'b0000, 4'b1111);
    rst_n = 1'b1;

    // table walk, random masks per row
    for (int r = 0; r < NVEC; r++) begin
      @(posedge clk);
      {seed, in_v, casc_in, cen} = VEC[r];
      rng = seed;
      rand_cfg();
      run_model();
      check("R9", $sformatf("table row %0d", r), exp_xor, exp_casc, exp_fb);
    end

    // R9 free random
    rng = 32'hC0DE_5EED;
    for (int i = 0; i < 150; i++) begin
      @(posedge clk);
      rand_cfg();
      in_v = NUM_IN'(nxt());
      seed = nxt();
      casc_in = seed[0];
      cen = seed[4:1];
      run_model();
      check("R9", $sformatf("random %0d", i), exp_xor, exp_casc, exp_fb);
    end

    // R1 empty enabled term is 1
    @(posedge clk); clear_cfg();
    set_term(0, 0, 1'b1, '0, '0);
    check("R1", "empty term", 4'b0001, 4'b0001, 4'b1110);

    // R1 literal polarity: in0 true, in1 complemented
    @(posedge clk); clear_cfg();
    set_term(0, 0, 1'b1, LW'(1), LW'(2));
    in_v = 16'h0001;
    check("R1", "literals met", 4'b0001, 4'b0001, 4'b1110);
    @(posedge clk); in_v = 16'h0003;
    check("R1", "literal missed", 4'b0000, 4'b0000, 4'b1111);
    @(posedge clk); set_term(0, 0, 1'b0, '0, '0); in_v = 16'h0001;
    check("R1", "disabled term", 4'b0000, 4'b0000, 4'b1111);

    // R4 constant operands
    @(posedge clk); clear_cfg();
    set_term(1, 2, 1'b1, '0, '0);
    set_mc(1, 2'd1, 3'd0, 3'd0);
    set_mc(2, 2'd1, 3'd0, 3'd0);
    check("R4", "const1", 4'b0100, 4'b0010, 4'b1111);
    @(posedge clk); set_mc(1, 2'd3, 3'd0, 3'd0); set_mc(2, 2'd0, 3'd0, 3'd0);
    check("R4", "code3 const0", 4'b0010, 4'b0010, 4'b1111);

    // R5 steered term leaves the sum
    @(posedge clk); clear_cfg();
    set_term(0, 3, 1'b1, '0, '0);
    set_term(0, 1, 1'b1, LW'(1), '0);
    set_mc(0, 2'd2, 3'd3, 3'd0);
    check("R5", "steered only", 4'b0001, 4'b0000, 4'b1111);
    @(posedge clk); in_v = 16'h0001;
    check("R5", "other term on", 4'b0000, 4'b0001, 4'b1111);

    // R3 cascade chain
    @(posedge clk); clear_cfg();
    casc_in = 1'b1; cen = 4'b1111;
    check("R3", "full chain", 4'b1111, 4'b1111, 4'b1111);
    @(posedge clk); cen = 4'b1011;
    check("R3", "broken link", 4'b0011, 4'b0011, 4'b1111);
    // cascade and steering in the same macrocell
    @(posedge clk); cen = 4'b1111;
    set_term(1, 0, 1'b1, '0, '0);
    set_mc(1, 2'd2, 3'd0, 3'd0);
    check("R3", "cascade with steer R5", 4'b1101, 4'b1111, 4'b1101);

    // R6 foldback literal
    @(posedge clk); clear_cfg();
    set_term(0, 0, 1'b1, LW'(1), '0);
    set_term(1, 1, 1'b1, LW'(1) << NUM_IN, '0);
    in_v = 16'h0001;
    check("R6", "fb line low", 4'b0001, 4'b0001, 4'b1110);
    @(posedge clk); in_v = 16'h0000;
    check("R6", "fb line high", 4'b0010, 4'b0010, 4'b1111);

    // R7 foldback source ignores its own foldback literals
    @(posedge clk); clear_cfg();
    set_term(2, 0, 1'b1, '0, LW'(1) << (NUM_IN + 2));
    set_term(3, 1, 1'b1, LW'(1) << (NUM_IN + 2), '0);
    check("R7", "self literal", 4'b0100, 4'b0100, 4'b1011);

    // R8 out-of-range indices
    @(posedge clk); clear_cfg();
    for (int k = 0; k < NUM_PT; k++) set_term(3, k, 1'b1, '0, '0);
    set_mc(3, 2'd2, 3'd6, 3'd7);
    check("R8", "index 6/7", 4'b1000, 4'b1000, 4'b1111);
    @(posedge clk); set_mc(3, 2'd2, 3'd5, 3'd5);
    check("R8", "index 5", 4'b1000, 4'b1000, 4'b1111);
    @(posedge clk); set_mc(3, 2'd2, 3'd5, 3'd4);
    check("R8", "in-range fb", 4'b1000, 4'b1000, 4'b0111);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule